// File: doc/BRIEF.md
# Privilege-Masked Protection Register File

This block holds three 64-bit protection registers for a processor core: an access-mask register, a user mask-override register and a supervisor mask-override register. Software reaches them through a special-register write port and a read port. Each access carries a register number and the current privilege state, given as a problem-state flag and a hypervisor flag. From these the block decides one of three outcomes. The access is performed in full, performed as a masked merge, or refused as an illegal access.

A masked write keeps every bit outside the mask and replaces every bit inside it: `new = (old & ~mask) | (data & mask)`. The mask comes from the override register that belongs to the level above the writer. Problem-state code may therefore change only the fields that the supervisor has handed down, and the supervisor may change only the fields that the hypervisor has handed down. The hypervisor writes every register without a mask.

The access-mask register answers to two numbers. The unprivileged alias is 13 and the privileged alias is 29. The user mask-override register is number 157 and the supervisor mask-override register is number 349. Reads are combinational from the stored state. Writes commit on the clock edge. A refused access raises a one-cycle flag in the cycle after it.

Top module: `prm_regfile`

## Requirements
- R1: A synchronous reset clears all three registers to zero and holds `ill_o` low.
- R2: Register numbers 13 and 29 reach the same access-mask storage, so a value written through one alias is read back through the other.
- R3: With `pr_i`=1, a write to number 13 changes only the access-mask bits that are set in the user mask-override register, following `(old & ~mask) | (data & mask)`.
- R4: With `pr_i`=0 and `hv_i`=0, a write to number 13 or 29 changes only the access-mask bits that are set in the supervisor mask-override register.
- R5: With `pr_i`=0 and `hv_i`=0, a write to number 157 changes only the user mask-override bits that are set in the supervisor mask-override register.
- R6: With `pr_i`=0 and `hv_i`=1, a write to number 13, 29, 157 or 349 stores the full data word.
- R7: The supervisor mask-override register (number 349) can be written only with `pr_i`=0 and `hv_i`=1. Any other write to it is illegal and leaves it unchanged. It can be read whenever `pr_i`=0.
- R8: With `pr_i`=1, whatever the value of `hv_i`, any read or write of numbers 29, 157 or 349 is illegal. Such a write changes no register, and such a read returns zero.
- R9: `ill_o` is high for exactly the cycle after a strobed access that the privilege state forbids, and low after every legal or unmapped access.
- R10: A number other than 13, 29, 157 or 349 is unmapped. Writing it changes nothing, reading it returns zero, and neither raises `ill_o`.
- R11: A write commits on the clock edge where `wr_en_i` is high. A read in that same cycle returns the old value, and a read in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pr_i | input | 1 | Problem-state (user) flag of the current access |
| hv_i | input | 1 | Hypervisor flag of the current access |
| wr_en_i | input | 1 | Write strobe |
| wr_num_i | input | 10 | Register number of the write |
| wr_data_i | input | 64 | Write data word |
| rd_en_i | input | 1 | Read strobe |
| rd_num_i | input | 10 | Register number of the read |
| rd_data_o | output | 64 | Read data; zero when the read is idle, unmapped or forbidden |
| ill_o | output | 1 | Illegal-access pulse, one cycle after a forbidden access |

## Verification
The masked merge is driven with all-ones data, zero data and mixed patterns over mask registers that hold sparse and dense bit sets. Mixed data shows that bits outside the mask keep their old value. All-ones data and zero data show separately that set bits and cleared bits inside the mask pass through. Each register number is accessed from the user, supervisor and hypervisor states. This separates the full-write, masked-write and refused outcomes, including a write with both flags set, which must follow the problem-state rules. After each refused write, a read shows that the target is unchanged. Unmapped numbers, a read in the same cycle as a write, and a reset in the middle of the run cover the remaining edges.

// File: rtl/prm_pkg.sv
package prm_pkg;

   localparam int unsigned PRM_NREG = 3;

   typedef enum logic [1:0] {
      SEL_AMASK = 2'd0,
      SEL_UOVR  = 2'd1,
      SEL_SOVR  = 2'd2
   } reg_sel_e;

   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_SUP  = 2'd1,
      PRIV_HYP  = 2'd2
   } priv_e;

   typedef enum logic [1:0] {
      MSK_FULL = 2'd0,
      MSK_UOVR = 2'd1,
      MSK_SOVR = 2'd2
   } msk_src_e;

   typedef struct packed {
      logic     hit;
      logic     legal;
      reg_sel_e sel;
      msk_src_e msk;
   } acc_t;

   // Problem state dominates: a set problem flag always means user level.
   function automatic priv_e priv_of(input logic pr, input logic hv);
      if (pr)      return PRIV_USER;
      else if (hv) return PRIV_HYP;
      else         return PRIV_SUP;
   endfunction

endpackage

// File: rtl/prm_decode.sv
module prm_decode
   import prm_pkg::*;
#(
   parameter int unsigned NUM_W          = 10,
   parameter int unsigned AMASK_USER_NUM = 13,
   parameter int unsigned AMASK_PRIV_NUM = 29,
   parameter int unsigned UOVR_NUM       = 157,
   parameter int unsigned SOVR_NUM       = 349,
   parameter bit          IS_WRITE       = 1'b1
) (
   input  logic [NUM_W-1:0] num_i,
   input  logic             pr_i,
   input  logic             hv_i,
   output acc_t             acc_o
);

   localparam logic [NUM_W-1:0] N_AU = NUM_W'(AMASK_USER_NUM);
   localparam logic [NUM_W-1:0] N_AP = NUM_W'(AMASK_PRIV_NUM);
   localparam logic [NUM_W-1:0] N_UO = NUM_W'(UOVR_NUM);
   localparam logic [NUM_W-1:0] N_SO = NUM_W'(SOVR_NUM);

   priv_e lvl;

   assign lvl = priv_of(pr_i, hv_i);

   always_comb begin
      acc_o.hit   = 1'b0;
      acc_o.legal = 1'b0;
      acc_o.sel   = SEL_AMASK;
      acc_o.msk   = MSK_FULL;
      unique case (num_i)
         N_AU, N_AP: begin
            acc_o.hit = 1'b1;
            acc_o.sel = SEL_AMASK;
            unique case (lvl)
               PRIV_USER: begin
                  acc_o.legal = (num_i == N_AU);
                  acc_o.msk   = MSK_UOVR;
               end
               PRIV_SUP: begin
                  acc_o.legal = 1'b1;
                  acc_o.msk   = MSK_SOVR;
               end
               default: begin
                  acc_o.legal = 1'b1;
                  acc_o.msk   = MSK_FULL;
               end
            endcase
         end
         N_UO: begin
            acc_o.hit = 1'b1;
            acc_o.sel = SEL_UOVR;
            unique case (lvl)
               PRIV_USER: acc_o.legal = 1'b0;
               PRIV_SUP: begin
                  acc_o.legal = 1'b1;
                  acc_o.msk   = MSK_SOVR;
               end
               default: begin
                  acc_o.legal = 1'b1;
                  acc_o.msk   = MSK_FULL;
               end
            endcase
         end
         N_SO: begin
            acc_o.hit = 1'b1;
            acc_o.sel = SEL_SOVR;
            unique case (lvl)
               PRIV_USER: acc_o.legal = 1'b0;
               PRIV_SUP:  acc_o.legal = !IS_WRITE;
               default:   acc_o.legal = 1'b1;
            endcase
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/prm_merge.sv
module prm_merge #(
   parameter int unsigned XLEN    = 64,
   parameter bit          BITWISE = 1'b0
) (
   input  logic [XLEN-1:0] old_i,
   input  logic [XLEN-1:0] data_i,
   input  logic [XLEN-1:0] mask_i,
   output logic [XLEN-1:0] new_o
);

   generate
      if (BITWISE) begin : g_bitmux
         for (genvar b = 0; b < XLEN; b++) begin : g_bit
            assign new_o[b] = mask_i[b] ? data_i[b] : old_i[b];
         end
      end else begin : g_vector
         assign new_o = (old_i & ~mask_i) | (data_i & mask_i);
      end
   endgenerate

endmodule

// File: rtl/prm_bank.sv
module prm_bank
   import prm_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            we_i,
   input  reg_sel_e        sel_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] amask_o,
   output logic [XLEN-1:0] uovr_o,
   output logic [XLEN-1:0] sovr_o
);

   logic [PRM_NREG-1:0][XLEN-1:0] q;

   generate
      for (genvar r = 0; r < PRM_NREG; r++) begin : g_reg
         always_ff @(posedge clk_i) begin
            if (rst_i)
               q[r] <= '0;
            else if (we_i && (sel_i == reg_sel_e'(r)))
               q[r] <= wdata_i;
         end
      end
   endgenerate

   assign amask_o = q[SEL_AMASK];
   assign uovr_o  = q[SEL_UOVR];
   assign sovr_o  = q[SEL_SOVR];

endmodule

// File: rtl/prm_regfile.sv
module prm_regfile
   import prm_pkg::*;
#(
   parameter int unsigned XLEN           = 64,
   parameter int unsigned NUM_W          = 10,
   parameter int unsigned AMASK_USER_NUM = 13,
   parameter int unsigned AMASK_PRIV_NUM = 29,
   parameter int unsigned UOVR_NUM       = 157,
   parameter int unsigned SOVR_NUM       = 349,
   parameter bit          MERGE_BITWISE  = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             pr_i,
   input  logic             hv_i,
   input  logic             wr_en_i,
   input  logic [NUM_W-1:0] wr_num_i,
   input  logic [XLEN-1:0]  wr_data_i,
   input  logic             rd_en_i,
   input  logic [NUM_W-1:0] rd_num_i,
   output logic [XLEN-1:0]  rd_data_o,
   output logic             ill_o
);

   localparam longint unsigned NUM_SPAN = 64'd1 << NUM_W;

   generate
      if (XLEN < 1) begin : g_bad_xlen
         $error("prm_regfile: XLEN must be at least 1");
      end
      if (NUM_W < 1 || NUM_W > 32) begin : g_bad_numw
         $error("prm_regfile: NUM_W must lie in 1..32");
      end
      if (AMASK_USER_NUM >= NUM_SPAN || AMASK_PRIV_NUM >= NUM_SPAN ||
          UOVR_NUM >= NUM_SPAN || SOVR_NUM >= NUM_SPAN) begin : g_bad_num
         $error("prm_regfile: a register number does not fit NUM_W");
      end
      if (AMASK_USER_NUM == AMASK_PRIV_NUM || AMASK_USER_NUM == UOVR_NUM ||
          AMASK_USER_NUM == SOVR_NUM || AMASK_PRIV_NUM == UOVR_NUM ||
          AMASK_PRIV_NUM == SOVR_NUM || UOVR_NUM == SOVR_NUM) begin : g_dup_num
         $error("prm_regfile: register numbers must be distinct");
      end
   endgenerate

   acc_t            wr_acc;
   acc_t            rd_acc;
   logic [XLEN-1:0] amask_q;
   logic [XLEN-1:0] uovr_q;
   logic [XLEN-1:0] sovr_q;
   logic [XLEN-1:0] wr_old;
   logic [XLEN-1:0] wr_mask;
   logic [XLEN-1:0] wr_new;
   logic [XLEN-1:0] rd_val;
   logic            wr_commit;
   logic            ill_d;
   logic            ill_q;
   logic            unused_rd_msk;

   prm_decode #(
      .NUM_W(NUM_W), .AMASK_USER_NUM(AMASK_USER_NUM), .AMASK_PRIV_NUM(AMASK_PRIV_NUM),
      .UOVR_NUM(UOVR_NUM), .SOVR_NUM(SOVR_NUM), .IS_WRITE(1'b1)
   ) wr_dec_i (
      .num_i(wr_num_i), .pr_i(pr_i), .hv_i(hv_i), .acc_o(wr_acc)
   );

   prm_decode #(
      .NUM_W(NUM_W), .AMASK_USER_NUM(AMASK_USER_NUM), .AMASK_PRIV_NUM(AMASK_PRIV_NUM),
      .UOVR_NUM(UOVR_NUM), .SOVR_NUM(SOVR_NUM), .IS_WRITE(1'b0)
   ) rd_dec_i (
      .num_i(rd_num_i), .pr_i(pr_i), .hv_i(hv_i), .acc_o(rd_acc)
   );

   assign unused_rd_msk = ^rd_acc.msk;

   always_comb begin
      unique case (wr_acc.sel)
         SEL_UOVR: wr_old = uovr_q;
         SEL_SOVR: wr_old = sovr_q;
         default:  wr_old = amask_q;
      endcase
      unique case (wr_acc.msk)
         MSK_UOVR: wr_mask = uovr_q;
         MSK_SOVR: wr_mask = sovr_q;
         default:  wr_mask = '1;
      endcase
   end

   prm_merge #(.XLEN(XLEN), .BITWISE(MERGE_BITWISE)) merge_i (
      .old_i(wr_old), .data_i(wr_data_i), .mask_i(wr_mask), .new_o(wr_new)
   );

   assign wr_commit = wr_en_i && wr_acc.hit && wr_acc.legal;

   prm_bank #(.XLEN(XLEN)) bank_i (
      .clk_i(clk_i), .rst_i(rst_i), .we_i(wr_commit), .sel_i(wr_acc.sel),
      .wdata_i(wr_new), .amask_o(amask_q), .uovr_o(uovr_q), .sovr_o(sovr_q)
   );

   always_comb begin
      unique case (rd_acc.sel)
         SEL_UOVR: rd_val = uovr_q;
         SEL_SOVR: rd_val = sovr_q;
         default:  rd_val = amask_q;
      endcase
   end

   assign rd_data_o = (rd_en_i && rd_acc.hit && rd_acc.legal) ? rd_val : '0;

   assign ill_d = (wr_en_i && wr_acc.hit && !wr_acc.legal) ||
                  (rd_en_i && rd_acc.hit && !rd_acc.legal);

   always_ff @(posedge clk_i) begin
      if (rst_i) ill_q <= 1'b0;
      else       ill_q <= ill_d;
   end

   assign ill_o = ill_q;

endmodule

// File: rtl/prm_regfile_chk.sv
module prm_regfile_chk #(
   parameter int unsigned XLEN           = 64,
   parameter int unsigned NUM_W          = 10,
   parameter int unsigned AMASK_USER_NUM = 13,
   parameter int unsigned AMASK_PRIV_NUM = 29,
   parameter int unsigned UOVR_NUM       = 157,
   parameter int unsigned SOVR_NUM       = 349
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             pr_i,
   input logic             hv_i,
   input logic             wr_en_i,
   input logic [NUM_W-1:0] wr_num_i,
   input logic [XLEN-1:0]  wr_data_i,
   input logic             rd_en_i,
   input logic [NUM_W-1:0] rd_num_i,
   input logic [XLEN-1:0]  rd_data_o,
   input logic             ill_o,
   input logic [XLEN-1:0]  amask,
   input logic [XLEN-1:0]  uovr,
   input logic [XLEN-1:0]  sovr
);

   localparam logic [NUM_W-1:0] N_AU = NUM_W'(AMASK_USER_NUM);
   localparam logic [NUM_W-1:0] N_AP = NUM_W'(AMASK_PRIV_NUM);
   localparam logic [NUM_W-1:0] N_UO = NUM_W'(UOVR_NUM);
   localparam logic [NUM_W-1:0] N_SO = NUM_W'(SOVR_NUM);

   AST_RESET_CLEAR: assert property (@(posedge clk_i) $past(rst_i) |-> (amask == '0 && uovr == '0 && sovr == '0 && !ill_o)); // R1

   AST_ALIAS_READ: assert property (@(posedge clk_i) disable iff (rst_i) (rd_en_i && !pr_i && rd_num_i == N_AU) |-> (rd_data_o == amask)); // R2

   AST_USER_AMASK_MASK: assert property (@(posedge clk_i) disable iff (rst_i) (wr_en_i && pr_i && wr_num_i == N_AU) |=> (((amask ^ $past(amask)) & ~$past(uovr)) == '0)); // R3

   AST_SUP_AMASK_MASK: assert property (@(posedge clk_i) disable iff (rst_i) (wr_en_i && !pr_i && !hv_i && (wr_num_i == N_AU || wr_num_i == N_AP)) |=> (((amask ^ $past(amask)) & ~$past(sovr)) == '0)); // R4

   AST_SUP_UOVR_MASK: assert property (@(posedge clk_i) disable iff (rst_i) (wr_en_i && !pr_i && !hv_i && wr_num_i == N_UO) |=> (((uovr ^ $past(uovr)) & ~$past(sovr)) == '0)); // R5

   AST_HYP_FULL_WRITE: assert property (@(posedge clk_i) disable iff (rst_i) (wr_en_i && !pr_i && hv_i && wr_num_i == N_SO) |=> (sovr == $past(wr_data_i))); // R6

   AST_SOVR_GUARD: assert property (@(posedge clk_i) disable iff (rst_i) (wr_en_i && (pr_i || !hv_i) && wr_num_i == N_SO) |=> $stable(sovr)); // R7

   AST_USER_READ_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i) (rd_en_i && pr_i && (rd_num_i == N_AP || rd_num_i == N_UO || rd_num_i == N_SO)) |-> (rd_data_o == '0)); // R8

   AST_ILL_FROM_ACCESS: assert property (@(posedge clk_i) disable iff (rst_i) ill_o |-> $past(wr_en_i || rd_en_i)); // R9

   AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (rst_i) (rd_en_i && rd_num_i != N_AU && rd_num_i != N_AP && rd_num_i != N_UO && rd_num_i != N_SO) |-> (rd_data_o == '0)); // R10

   AST_UNMAPPED_WRITE: assert property (@(posedge clk_i) disable iff (rst_i) (wr_en_i && !rd_en_i && wr_num_i != N_AU && wr_num_i != N_AP && wr_num_i != N_UO && wr_num_i != N_SO) |=> ($stable(amask) && $stable(uovr) && $stable(sovr) && !ill_o)); // R10

endmodule

bind prm_regfile prm_regfile_chk #(
   .XLEN(XLEN), .NUM_W(NUM_W), .AMASK_USER_NUM(AMASK_USER_NUM),
   .AMASK_PRIV_NUM(AMASK_PRIV_NUM), .UOVR_NUM(UOVR_NUM), .SOVR_NUM(SOVR_NUM)
) chk_i (
   .clk_i(clk_i), .rst_i(rst_i), .pr_i(pr_i), .hv_i(hv_i),
   .wr_en_i(wr_en_i), .wr_num_i(wr_num_i), .wr_data_i(wr_data_i),
   .rd_en_i(rd_en_i), .rd_num_i(rd_num_i), .rd_data_o(rd_data_o), .ill_o(ill_o),
   .amask(amask_q), .uovr(uovr_q), .sovr(sovr_q)
);

// File: tb/prm_regfile_tb_top.sv
module prm_regfile_tb_top;

   localparam logic [9:0] AU = 10'd13;
   localparam logic [9:0] AP = 10'd29;
   localparam logic [9:0] UO = 10'd157;
   localparam logic [9:0] SO = 10'd349;
   localparam logic [9:0] NX = 10'd500;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] SPAT = 64'hF0F0_F0F0_0000_FFFF;
   localparam logic [63:0] HPAT = 64'h0123_4567_89AB_CDEF;

   typedef struct packed {
      logic        wr;
      logic [9:0]  num;
      logic        pr;
      logic        hv;
      logic [63:0] data;
      logic [63:0] exp_rd;
      logic        exp_ill;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 27;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, SO, 1'b0, 1'b1, SPAT, 64'h0, 1'b0, 4'd6},                     // R6 hyp full write
      '{1'b0, SO, 1'b0, 1'b0, 64'h0, SPAT, 1'b0, 4'd7},                     // R7 supervisor read
      '{1'b1, SO, 1'b0, 1'b0, ONES, 64'h0, 1'b1, 4'd7},                     // R7 supervisor write refused
      '{1'b0, SO, 1'b0, 1'b1, 64'h0, SPAT, 1'b0, 4'd7},                     // R7 unchanged
      '{1'b1, UO, 1'b0, 1'b0, ONES, 64'h0, 1'b0, 4'd5},                     // R5 masked by sovr
      '{1'b0, UO, 1'b0, 1'b1, 64'h0, SPAT, 1'b0, 4'd5},                     // R5 result
      '{1'b1, UO, 1'b0, 1'b1, 64'h0000_0000_0000_00FF, 64'h0, 1'b0, 4'd6},  // R6 full write
      '{1'b0, UO, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_00FF, 1'b0, 4'd6},  // R6 result
      '{1'b1, AU, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0, 4'd3},  // R3 masked by uovr
      '{1'b0, AU, 1'b1, 1'b0, 64'h0, 64'h0000_0000_0000_00F0, 1'b0, 4'd3},  // R3 result
      '{1'b1, AP, 1'b0, 1'b0, ONES, 64'h0, 1'b0, 4'd4},                     // R4 masked by sovr
      '{1'b0, AP, 1'b0, 1'b1, 64'h0, SPAT, 1'b0, 4'd4},                     // R4 result
      '{1'b1, AP, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8},                    // R8 user write alias 29
      '{1'b0, AP, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8},                    // R8 user read alias 29
      '{1'b0, UO, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8},                    // R8 user read uovr
      '{1'b1, UO, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8},                    // R8 user write uovr
      '{1'b1, AU, 1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 4'd3},                    // R3 clear inside mask
      '{1'b0, AU, 1'b1, 1'b0, 64'h0, 64'hF0F0_F0F0_0000_FF00, 1'b0, 4'd3},  // R3 result
      '{1'b1, AU, 1'b0, 1'b1, HPAT, 64'h0, 1'b0, 4'd6},                     // R6 hyp via 13
      '{1'b0, AP, 1'b0, 1'b0, 64'h0, HPAT, 1'b0, 4'd2},                     // R2 alias read
      '{1'b0, SO, 1'b1, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8},                    // R8 user read sovr
      '{1'b1, NX, 1'b0, 1'b1, ONES, 64'h0, 1'b0, 4'd10},                    // R10 unmapped write
      '{1'b0, AU, 1'b1, 1'b0, 64'h0, HPAT, 1'b0, 4'd10},                    // R10 nothing changed
      '{1'b0, NX, 1'b0, 1'b1, 64'h0, 64'h0, 1'b0, 4'd10},                   // R10 unmapped read
      '{1'b1, SO, 1'b1, 1'b1, ONES, 64'h0, 1'b1, 4'd8},                     // R8 pr dominates hv
      '{1'b0, SO, 1'b0, 1'b1, 64'h0, SPAT, 1'b0, 4'd7},                     // R7 sovr unchanged
      '{1'b0, UO, 1'b0, 1'b0, 64'h0, 64'h0000_0000_0000_00FF, 1'b0, 4'd8}   // R8 uovr unchanged
   };

   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic        pr_i = 1'b0;
   logic        hv_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [9:0]  wr_num_i = '0;
   logic [63:0] wr_data_i = '0;
   logic        rd_en_i = 1'b0;
   logic [9:0]  rd_num_i = '0;
   logic [63:0] rd_data_o;
   logic        ill_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk_i = ~clk_i;

   prm_regfile dut_i (
      .clk_i(clk_i), .rst_i(rst_i), .pr_i(pr_i), .hv_i(hv_i),
      .wr_en_i(wr_en_i), .wr_num_i(wr_num_i), .wr_data_i(wr_data_i),
      .rd_en_i(rd_en_i), .rd_num_i(rd_num_i), .rd_data_o(rd_data_o), .ill_o(ill_o)
   );

   task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Called at a negative edge; leaves the bench at the next negative edge.
   task automatic run_vec(input vec_t v);
      string tag;
      tag = $sformatf("R%0d", v.req);
      pr_i = v.pr;
      hv_i = v.hv;
      if (v.wr) begin
         wr_en_i = 1'b1; wr_num_i = v.num; wr_data_i = v.data;
      end else begin
         rd_en_i = 1'b1; rd_num_i = v.num;
      end
      #1;
      if (!v.wr) chk64(tag, rd_data_o, v.exp_rd);
      @(posedge clk_i);
      @(negedge clk_i);
      wr_en_i = 1'b0;
      rd_en_i = 1'b0;
      chk1({tag, " ill"}, ill_o, v.exp_ill);
   endtask

   task automatic rd_now(input logic [9:0] num, input string req, input logic [63:0] exp);
      pr_i = 1'b0; hv_i = 1'b1; rd_en_i = 1'b1; rd_num_i = num;
      #1;
      chk64(req, rd_data_o, exp);
      rd_en_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_i = 1'b0;
      // R1: reset state at the ports
      chk1("R1 ill", ill_o, 1'b0);
      rd_now(AU, "R1 amask", 64'h0);
      rd_now(UO, "R1 uovr", 64'h0);
      rd_now(SO, "R1 sovr", 64'h0);

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // R11: read in the write cycle returns old, next cycle returns new
      pr_i = 1'b0; hv_i = 1'b1;
      wr_en_i = 1'b1; wr_num_i = AU; wr_data_i = 64'hA5A5_5A5A_C3C3_3C3C;
      rd_en_i = 1'b1; rd_num_i = AU;
      #1;
      chk64("R11 same cycle", rd_data_o, HPAT);
      @(posedge clk_i);
      @(negedge clk_i);
      wr_en_i = 1'b0;
      #1;
      chk64("R11 next cycle", rd_data_o, 64'hA5A5_5A5A_C3C3_3C3C);
      rd_en_i = 1'b0;

      // R9: back-to-back forbidden accesses give back-to-back pulses, then low
      @(negedge clk_i);
      pr_i = 1'b1; rd_en_i = 1'b1; rd_num_i = SO;
      @(posedge clk_i);
      @(negedge clk_i);
      chk1("R9 first pulse", ill_o, 1'b1);
      rd_num_i = AU;
      @(posedge clk_i);
      @(negedge clk_i);
      rd_en_i = 1'b0;
      chk1("R9 legal after illegal", ill_o, 1'b0);

      // R1: reset in the middle of the run clears stored state
      rst_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      rst_i = 1'b0;
      rd_now(AP, "R1 mid amask", 64'h0);
      rd_now(UO, "R1 mid uovr", 64'h0);
      rd_now(SO, "R1 mid sovr", 64'h0);

      @(negedge clk_i);
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk_i);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule